// File: doc/BRIEF.md
# Multi-Mode Shift-Rotate Unit

This block is a purely combinational shift and rotate unit for a processor datapath. It takes a 16-bit operand, a 4-bit unsigned distance, a 3-bit operation code and a carry input. From these it produces a 16-bit result and a carry output. There is no clock, no reset and no handshake. The outputs follow the inputs once the logic settles, so the block drops straight into an execute stage.

Eight operations are supported: logical and arithmetic shifts in both directions, plain 16-bit rotates in both directions, and 17-bit rotates through the carry in both directions. Right-direction operations reverse the operand at the input, reuse the left-moving datapath, and reverse the result again at the output.

The left-moving datapath is a chain of ranks built from two-input AND-OR select cells. There is one rank per distance bit, each 17 lanes wide: sixteen data lanes plus a carry lane. Each rank either holds a lane or moves it by a power of two. The lanes that empty out are refilled from a mode-selected wrap source. A separate control decoder drives the select pair of every cell.

Top module: `shf_unit`

## Requirements
- R1: When the distance is 0, the result equals the operand and the carry output equals the carry input, for every operation code.
- R2: Bit 0 of the operation code selects direction (0 = left, 1 = right). Bits 2:1 select the kind: 00 logical shift, 01 arithmetic shift, 10 plain rotate, 11 rotate through carry. The eight codes are therefore 000 SHL, 001 SHR, 010 ASL, 011 ASR, 100 ROL, 101 ROR, 110 RCL, 111 RCR.
- R3: Logical shift left by k (1..15) fills the low k bits with 0. The carry output is operand bit 16-k, the last bit moved out.
- R4: Logical shift right by k (1..15) fills the high k bits with 0. The carry output is operand bit k-1.
- R5: Arithmetic shift right by k (1..15) fills the high k bits with operand bit 15. The carry output is operand bit k-1.
- R6: Plain rotates move the 16 data bits around a 16-bit ring. For k ≥ 1, the carry output is the bit that wrapped into the end position: result bit 0 for a left rotate, result bit 15 for a right rotate.
- R7: Rotates through carry move the 17-bit ring {carry, operand}. Bit 16 of the rotated ring is the carry output and bits 15:0 are the result.
- R8: With operand 0xB2C5, carry input 0 and distance 2, the expected outputs are:

  | Code | Result | Carry output |
  |------|--------|--------------|
  | 000  | 0xCB14 | 0 |
  | 010  | 0xCB14 | 0 |
  | 100  | 0xCB16 | 0 |
  | 110  | 0xCB15 | 0 |
- R9: The outputs depend only on the present inputs, with no clock edge needed between an input change and the new output.
- R10: Arithmetic shift left gives the same result and carry output as logical shift left.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | 16 | Data word to shift or rotate |
| amount_i | input | 4 | Unsigned distance, 0 to 15 |
| op_i | input | 3 | Operation code (see R2) |
| carry_i | input | 1 | Carry input, used by the through-carry rotates and by distance 0 |
| result_o | output | 16 | Shifted or rotated word |
| carry_o | output | 1 | Carry output |

## Verification
The hardest cases to reach are those where the carry lane and the data lanes must carry different values through several ranks at once. Examples are a right rotate through carry whose ring wraps the carry into the middle of the word, and a plain rotate at distance 0, where the carry output must keep the carry input rather than the lane-0 bit. The stimulus sweeps all eight codes over all sixteen distances. Operands include 0x8000, 0x0001 and 0xFFFF, each paired with a carry input opposite to the end bits, plus random words. This makes every lane-to-carry mix-up show up as a wrong bit.

// File: rtl/shf_pkg.sv
package shf_pkg;
  // Operation code: bit 0 = direction, bits 2:1 = kind
  typedef enum logic [2:0] {
    OP_SHL = 3'b000,
    OP_SHR = 3'b001,
    OP_ASL = 3'b010,
    OP_ASR = 3'b011,
    OP_ROL = 3'b100,
    OP_ROR = 3'b101,
    OP_RCL = 3'b110,
    OP_RCR = 3'b111
  } shf_op_e;

  localparam logic [1:0] KIND_LOGIC = 2'b00;
  localparam logic [1:0] KIND_ARITH = 2'b01;
  localparam logic [1:0] KIND_ROT   = 2'b10;
  localparam logic [1:0] KIND_RCARRY = 2'b11;
endpackage

// File: rtl/shf_aocell.sv
module shf_aocell (
  input  logic c1,
  input  logic in1,
  input  logic c2,
  input  logic in2,
  output logic f
);
  assign f = (c1 & in1) | (c2 & in2);
endmodule

// File: rtl/shf_steer.sv
// Direction steering rank: passes the word straight or bit-reversed.
module shf_steer #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] d,
  input  logic             fwd,
  input  logic             rev,
  output logic [WIDTH-1:0] y
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    shf_aocell u_cell (
      .c1 (fwd),
      .in1(d[i]),
      .c2 (rev),
      .in2(d[WIDTH-1-i]),
      .f  (y[i])
    );
  end
endmodule

// File: rtl/shf_ctrl.sv
// Control decoder: turns operation code and distance into cell select pairs.
module shf_ctrl
  import shf_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int AMT_W = $clog2(WIDTH),
  localparam int LANES = WIDTH + 1
) (
  input  logic [2:0]                  op,
  input  logic [AMT_W-1:0]            amt,
  input  logic                        sign_bit,
  output logic                        steer_fwd,
  output logic                        steer_rev,
  output logic [AMT_W-1:0][LANES-1:0] hold,
  output logic [AMT_W-1:0][LANES-1:0] move,
  output logic                        wrap_r17,
  output logic                        wrap_r16,
  output logic                        wrap_fill,
  output logic                        fill_bit,
  output logic                        co_lane0,
  output logic                        co_ltop
);
  logic [1:0] kind;
  logic       right;

  assign kind      = op[2:1];
  assign right     = op[0];
  assign steer_fwd = ~right;
  assign steer_rev = right;
  assign wrap_r17  = (kind == KIND_RCARRY);
  assign wrap_r16  = (kind == KIND_ROT);
  assign wrap_fill = ~kind[1];
  assign fill_bit  = (kind == KIND_ARITH) & right & sign_bit;

  // Plain rotate keeps the carry lane parked; it wraps the 16 data lanes only.
  for (genvar s = 0; s < AMT_W; s++) begin : g_stage
    for (genvar j = 0; j < LANES; j++) begin : g_lane
      if (j == LANES - 1) begin : g_top
        assign hold[s][j] = ~amt[s] | wrap_r16;
        assign move[s][j] = amt[s] & ~wrap_r16;
      end else begin : g_data
        assign hold[s][j] = ~amt[s];
        assign move[s][j] = amt[s];
      end
    end
  end

  // Plain rotate with a nonzero distance takes carry from the wrapped end lane.
  assign co_lane0 = wrap_r16 & (|amt);
  assign co_ltop  = ~co_lane0;
endmodule

// File: rtl/shf_rank.sv
// One distance rank: each lane holds or takes the lane DIST below it;
// lanes below DIST take a mode-selected wrap source.
module shf_rank #(
  parameter int LANES = 17,
  parameter int DIST  = 1
) (
  input  logic [LANES-1:0] v,
  input  logic [LANES-1:0] hold,
  input  logic [LANES-1:0] move,
  input  logic             wrap_r17,
  input  logic             wrap_r16,
  input  logic             wrap_fill,
  input  logic             fill_bit,
  output logic [LANES-1:0] y
);
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic src;
    if (j >= DIST) begin : g_inner
      assign src = v[j-DIST];
    end else begin : g_wrap
      assign src = (wrap_r17 & v[LANES+j-DIST])
                 | (wrap_r16 & v[LANES-1+j-DIST])
                 | (wrap_fill & fill_bit);
    end
    shf_aocell u_cell (
      .c1 (hold[j]),
      .in1(v[j]),
      .c2 (move[j]),
      .in2(src),
      .f  (y[j])
    );
  end
endmodule

// File: rtl/shf_unit.sv
module shf_unit #(
  parameter int WIDTH = 16,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] operand_i,
  input  logic [AMT_W-1:0] amount_i,
  input  logic [2:0]       op_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o
);
  localparam int LANES = WIDTH + 1;

  logic                        steer_fwd, steer_rev;
  logic [AMT_W-1:0][LANES-1:0] hold, move;
  logic                        wrap_r17, wrap_r16, wrap_fill, fill_bit;
  logic                        co_lane0, co_ltop;
  logic [WIDTH-1:0]            steered;
  logic [LANES-1:0]            lane_v [AMT_W+1];

  shf_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .op       (op_i),
    .amt      (amount_i),
    .sign_bit (operand_i[WIDTH-1]),
    .steer_fwd(steer_fwd),
    .steer_rev(steer_rev),
    .hold     (hold),
    .move     (move),
    .wrap_r17 (wrap_r17),
    .wrap_r16 (wrap_r16),
    .wrap_fill(wrap_fill),
    .fill_bit (fill_bit),
    .co_lane0 (co_lane0),
    .co_ltop  (co_ltop)
  );

  shf_steer #(.WIDTH(WIDTH)) u_steer_in (
    .d  (operand_i),
    .fwd(steer_fwd),
    .rev(steer_rev),
    .y  (steered)
  );

  assign lane_v[0] = {carry_i, steered};

  for (genvar s = 0; s < AMT_W; s++) begin : g_rank
    shf_rank #(.LANES(LANES), .DIST(1 << s)) u_rank (
      .v        (lane_v[s]),
      .hold     (hold[s]),
      .move     (move[s]),
      .wrap_r17 (wrap_r17),
      .wrap_r16 (wrap_r16),
      .wrap_fill(wrap_fill),
      .fill_bit (fill_bit),
      .y        (lane_v[s+1])
    );
  end

  shf_steer #(.WIDTH(WIDTH)) u_steer_out (
    .d  (lane_v[AMT_W][WIDTH-1:0]),
    .fwd(steer_fwd),
    .rev(steer_rev),
    .y  (result_o)
  );

  shf_aocell u_co (
    .c1 (co_lane0),
    .in1(lane_v[AMT_W][0]),
    .c2 (co_ltop),
    .in2(lane_v[AMT_W][LANES-1]),
    .f  (carry_o)
  );
endmodule

// File: rtl/shf_unit_chk.sv
module shf_unit_chk #(
  parameter int WIDTH = 16,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input logic [WIDTH-1:0] operand_i,
  input logic [AMT_W-1:0] amount_i,
  input logic [2:0]       op_i,
  input logic             carry_i,
  input logic [WIDTH-1:0] result_o,
  input logic             carry_o
);
  logic [WIDTH-1:0] low_mask;
  assign low_mask = (WIDTH'(1) << amount_i) - WIDTH'(1);

  always_comb begin
    if (amount_i == '0) begin
      p_zero_pass_r1: assert (result_o == operand_i && carry_o == carry_i)
        else $error("zero distance changed data or carry");
    end
    if (op_i[2] == 1'b0 && op_i[0] == 1'b0) begin
      // R3 / R10: left shifts leave zeros below the distance
      p_left_zero_fill_r3: assert ((result_o & low_mask) == '0)
        else $error("left shift fill not zero");
    end
    if (op_i == 3'b011) begin
      p_sign_keep_r5: assert (result_o[WIDTH-1] == operand_i[WIDTH-1])
        else $error("arithmetic right lost sign");
    end
    if (op_i[2:1] == 2'b10) begin
      p_rot_weight_r6: assert ($countones(result_o) == $countones(operand_i))
        else $error("plain rotate changed bit count");
    end
    if (op_i[2:1] == 2'b11) begin
      p_ring_weight_r7: assert ($countones({carry_o, result_o}) == $countones({carry_i, operand_i}))
        else $error("carry ring changed bit count");
    end
  end
endmodule

bind shf_unit shf_unit_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/shf_unit_tb.sv
module shf_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 16;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [W-1:0]  operand_i;
  logic [AW-1:0] amount_i;
  logic [2:0]    op_i;
  logic          carry_i;
  logic [W-1:0]  result_o;
  logic          carry_o;

  shf_unit u_dut (
    .operand_i(operand_i),
    .amount_i (amount_i),
    .op_i     (op_i),
    .carry_i  (carry_i),
    .result_o (result_o),
    .carry_o  (carry_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [W-1:0] res;
    logic         co;
    string        tag;
  } exp_t;
  exp_t sbq[$];

  function automatic void ref_model(input logic [2:0] op, input logic [W-1:0] d,
                                    input logic [AW-1:0] k, input logic c,
                                    output logic [W-1:0] r, output logic co);
    logic [2*W-1:0] t;
    logic [W:0]     ring;
    int             n;
    n = int'(k);
    r = d;
    co = c;
    case (op)
      3'b000, 3'b010: begin
        t = {{W{1'b0}}, d} << n;
        r = t[W-1:0];
        if (n != 0) co = t[W];
      end
      3'b001: begin
        t = {d, {W{1'b0}}} >> n;
        r = t[2*W-1:W];
        if (n != 0) co = t[W-1];
      end
      3'b011: begin
        t = $unsigned($signed({d, {W{1'b0}}}) >>> n);
        r = t[2*W-1:W];
        if (n != 0) co = t[W-1];
      end
      3'b100: begin
        if (n != 0) begin
          r = (d << n) | (d >> (W - n));
          co = r[0];
        end
      end
      3'b101: begin
        if (n != 0) begin
          r = (d >> n) | (d << (W - n));
          co = r[W-1];
        end
      end
      3'b110: begin
        ring = {c, d};
        for (int i = 0; i < n; i++) ring = {ring[W-1:0], ring[W]};
        r = ring[W-1:0];
        co = ring[W];
      end
      default: begin
        ring = {c, d};
        for (int i = 0; i < n; i++) ring = {ring[0], ring[W:1]};
        r = ring[W-1:0];
        co = ring[W];
      end
    endcase
  endfunction

  function automatic string op_tag(input logic [2:0] op, input logic [AW-1:0] k);
    if (k == '0) return "R1";
    case (op)
      3'b000: return "R3";
      3'b001: return "R4";
      3'b010: return "R10";
      3'b011: return "R5";
      3'b100, 3'b101: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic drive_exp(input logic [2:0] op, input logic [W-1:0] d,
                           input logic [AW-1:0] k, input logic c,
                           input logic [W-1:0] r, input logic co, input string tag);
    exp_t e;
    @(negedge clk);
    op_i = op; operand_i = d; amount_i = k; carry_i = c;
    e.res = r; e.co = co; e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic drive(input logic [2:0] op, input logic [W-1:0] d,
                       input logic [AW-1:0] k, input logic c);
    logic [W-1:0] r;
    logic         co;
    ref_model(op, d, k, c, r, co);
    drive_exp(op, d, k, c, r, co,
              $sformatf("R2/%s op=%b k=%0d d=%h c=%b", op_tag(op, k), op, k, d, c));
  endtask

  // Monitor: pops one expected item per rising edge, inputs were set at the falling edge
  always @(posedge clk) begin
    if (rst_n && sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      checks++;
      if (result_o !== e.res || carry_o !== e.co) begin
        fails++;
        $display("FAIL %s: actual result=%h carry=%b expected result=%h carry=%b",
                 e.tag, result_o, carry_o, e.res, e.co);
      end
    end
  end

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual run still busy expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    operand_i = '0; amount_i = '0; op_i = '0; carry_i = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Idle state: all-zero inputs give all-zero outputs (R1)
    drive_exp(3'b000, 16'h0000, 4'd0, 1'b0, 16'h0000, 1'b0, "R1 idle zero");

    // Fixed vector at distance 2 (R8, R3, R10, R6, R7)
    drive_exp(3'b000, 16'hB2C5, 4'd2, 1'b0, 16'hCB14, 1'b0, "R8 SHL vector");
    drive_exp(3'b010, 16'hB2C5, 4'd2, 1'b0, 16'hCB14, 1'b0, "R8 ASL vector R10");
    drive_exp(3'b100, 16'hB2C5, 4'd2, 1'b0, 16'hCB16, 1'b0, "R8 ROL vector");
    drive_exp(3'b110, 16'hB2C5, 4'd2, 1'b0, 16'hCB15, 1'b0, "R8 RCL vector");

    // Full sweep of codes and distances with edge and random operands
    for (int op = 0; op < 8; op++) begin
      for (int k = 0; k < 16; k++) begin
        drive(3'(op), 16'h8000, 4'(k), 1'b1);
        drive(3'(op), 16'h0001, 4'(k), 1'b0);
        drive(3'(op), 16'hFFFF, 4'(k), 1'b0);
        drive(3'(op), 16'h0000, 4'(k), 1'b1);
        for (int n = 0; n < 3; n++)
          drive(3'(op), 16'($urandom), 4'(k), 1'($urandom));
      end
    end

    // Drain the scoreboard
    while (sbq.size() > 0) @(posedge clk);
    @(negedge clk);

    // R9: output follows an input change with no clock edge in between
    begin
      logic [W-1:0] r;
      logic         co;
      op_i = 3'b111; operand_i = 16'h1234; amount_i = 4'd5; carry_i = 1'b1;
      #1;
      ref_model(3'b111, 16'h1234, 4'd5, 1'b1, r, co);
      checks++;
      if (result_o !== r || carry_o !== co) begin
        fails++;
        $display("FAIL R9 first: actual result=%h carry=%b expected result=%h carry=%b",
                 result_o, carry_o, r, co);
      end
      amount_i = 4'd9;
      #1;
      ref_model(3'b111, 16'h1234, 4'd9, 1'b1, r, co);
      checks++;
      if (result_o !== r || carry_o !== co) begin
        fails++;
        $display("FAIL R9 second: actual result=%h carry=%b expected result=%h carry=%b",
                 result_o, carry_o, r, co);
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule